// File: doc/BRIEF.md
# Byte-Addressable Word Data Memory

This block is a synchronous data store for a 32-bit load/store datapath. Storage is organised as 32-bit words, while the address presented to it counts bytes. A single size select picks between a full-word access and a single-byte access. For a byte load, the block picks the addressed byte out of the stored word and sign-extends it to 32 bits. For a byte store, the block replaces only the addressed byte of the stored word and keeps the other three; the read and the merge take place in the same cycle.

Word accesses must be aligned to a multiple of four. A word access with a nonzero offset inside the word raises an alignment error, and the access is dropped. Read data and the error flag are both registered and appear one clock after the strobe. The number of stored words is a power-of-two parameter. Address bits above the word index are ignored, so the address space wraps onto the storage.

Top module: `byte_word_dmem`

## Requirements
- R1: After reset, `rdata_o` is 0, `misalign_o` is 0, and every stored word reads as 0.
- R2: A word store (`size_i`=1, `wr_i`=1, address bits [1:0]=0) writes all 32 bits of `wdata_i`. A word load at that address returns them on `rdata_o` one clock after `rd_i`.
- R3: Storage is big-endian. The byte at offset k (address bits [1:0]=k) is bits [31-8k:24-8k] of the stored word, so offset 0 is the most significant byte.
- R4: A byte load (`size_i`=0) returns the selected byte in bits [7:0] of `rdata_o` and copies its bit 7 into bits [31:8].
- R5: A byte store writes `wdata_i[7:0]` into the addressed lane only, and leaves the other three bytes of that word unchanged.
- R6: A word access (read or write) whose address bits [1:0] are nonzero drives `misalign_o` to 1 one clock later. Such a store leaves memory unchanged, and such a load leaves `rdata_o` unchanged.
- R7: `misalign_o` is 0 one clock after any cycle with a byte access, an aligned word access or no access.
- R8: The word index is address bits [IDX_W+1:2] with IDX_W = log2(DEPTH_WORDS). Higher address bits are ignored, so addresses that differ by DEPTH_WORDS*4 reach the same word.
- R9: `rdata_o` keeps its value in any cycle after one where `rd_i` is 0.
- R10: When a read and a write reach the same word in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store data; bits [7:0] for a byte store |
| size_i | input | 1 | Access size: 1 = word, 0 = byte |
| rd_i | input | 1 | Load strobe |
| wr_i | input | 1 | Store strobe |
| rdata_o | output | 32 | Registered load data |
| misalign_o | output | 1 | Registered alignment error for a word access |

## Verification
A word with a distinct value in each byte, including bytes with the top bit set and clear, is read back one lane at a time. This shows whether the lane order is big-endian and whether sign extension is applied. Byte stores into each lane of a known word show whether a merge wrongly touches neighbouring lanes. Misaligned word stores and loads, and byte accesses at odd addresses, separate the error path from the normal path. Aliased addresses, reads and writes to the same word in one cycle, and a long mixed random stream compared every clock against a behavioural model cover the index slicing, the read-before-write order and the hold behaviour.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    parameter int unsigned WORD_BITS = 32;
    parameter int unsigned BYTE_BITS = 8;
    parameter int unsigned LANES     = WORD_BITS / BYTE_BITS;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic [WORD_BITS-1:0] rdata;
        logic                 misalign;
    } port_state_t;

endpackage

// File: rtl/dmem_align_chk.sv
module dmem_align_chk
    import dmem_pkg::*;
#(
    parameter int unsigned LANE_W = 2
) (
    input  logic [LANE_W-1:0] lane_i,
    input  acc_size_e         size_i,
    input  logic              access_i,
    output logic              misaligned_o
);

    // Only full-word accesses carry an alignment constraint.
    always_comb begin
        misaligned_o = 1'b0;
        if (access_i && (size_i == SZ_WORD)) begin
            misaligned_o = (lane_i != '0);
        end
    end

endmodule

// File: rtl/dmem_lane_sel.sv
module dmem_lane_sel
    import dmem_pkg::*;
#(
    parameter int unsigned LANE_W = 2
) (
    input  logic [WORD_BITS-1:0] word_i,
    input  logic [LANE_W-1:0]    lane_i,
    input  acc_size_e            size_i,
    output logic [WORD_BITS-1:0] data_o
);

    logic [BYTE_BITS-1:0] lane_bytes [LANES];
    logic [BYTE_BITS-1:0] picked;

    // Lane 0 is the most significant byte of the stored word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_i[WORD_BITS-1-g*BYTE_BITS -: BYTE_BITS];
    end

    assign picked = lane_bytes[lane_i];

    always_comb begin
        if (size_i == SZ_WORD) begin
            data_o = word_i;
        end else begin
            data_o = {{(WORD_BITS-BYTE_BITS){picked[BYTE_BITS-1]}}, picked};
        end
    end

endmodule

// File: rtl/dmem_lane_merge.sv
module dmem_lane_merge
    import dmem_pkg::*;
#(
    parameter int unsigned LANE_W = 2
) (
    input  logic [WORD_BITS-1:0] old_i,
    input  logic [WORD_BITS-1:0] new_i,
    input  logic [LANE_W-1:0]    lane_i,
    input  acc_size_e            size_i,
    output logic [WORD_BITS-1:0] word_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        localparam int unsigned HI = WORD_BITS - 1 - g * BYTE_BITS;
        logic hit;
        assign hit = (size_i == SZ_WORD) || (lane_i == LANE_W'(g));
        always_comb begin
            if (!hit) begin
                word_o[HI -: BYTE_BITS] = old_i[HI -: BYTE_BITS];
            end else if (size_i == SZ_WORD) begin
                word_o[HI -: BYTE_BITS] = new_i[HI -: BYTE_BITS];
            end else begin
                word_o[HI -: BYTE_BITS] = new_i[BYTE_BITS-1:0];
            end
        end
    end

endmodule

// File: rtl/byte_word_dmem.sv
module byte_word_dmem
    import dmem_pkg::*;
#(
    parameter int unsigned DEPTH_WORDS = 64,
    parameter int unsigned ADDR_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_BITS-1:0] wdata_i,
    input  logic                 size_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    output logic [WORD_BITS-1:0] rdata_o,
    output logic                 misalign_o
);

    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned IDX_W  = $clog2(DEPTH_WORDS);
    localparam int unsigned IDX_LO = LANE_W;
    localparam int unsigned IDX_HI = LANE_W + IDX_W - 1;

    acc_size_e            size_c;
    logic [LANE_W-1:0]    lane_c;
    logic [IDX_W-1:0]     idx_c;
    logic                 misal_c;
    logic [WORD_BITS-1:0] cur_word;
    logic [WORD_BITS-1:0] load_val;
    logic [WORD_BITS-1:0] merged;
    logic                 unused_addr_hi;

    logic [WORD_BITS-1:0] mem_q [DEPTH_WORDS];
    port_state_t          st_d, st_q;
    logic                 wr_en_d;

    assign size_c         = acc_size_e'(size_i);
    assign lane_c         = addr_i[LANE_W-1:0];
    assign idx_c          = addr_i[IDX_HI:IDX_LO];
    assign unused_addr_hi = ^addr_i[ADDR_W-1:IDX_HI+1];
    assign cur_word       = mem_q[idx_c];

    dmem_align_chk #(.LANE_W(LANE_W)) align_i (
        .lane_i       (lane_c),
        .size_i       (size_c),
        .access_i     (rd_i | wr_i),
        .misaligned_o (misal_c)
    );

    dmem_lane_sel #(.LANE_W(LANE_W)) sel_i (
        .word_i (cur_word),
        .lane_i (lane_c),
        .size_i (size_c),
        .data_o (load_val)
    );

    dmem_lane_merge #(.LANE_W(LANE_W)) merge_i (
        .old_i  (cur_word),
        .new_i  (wdata_i),
        .lane_i (lane_c),
        .size_i (size_c),
        .word_o (merged)
    );

    // Next-state computation: read sees pre-write contents.
    always_comb begin
        st_d          = st_q;
        st_d.misalign = misal_c;
        if (rd_i && !misal_c) begin
            st_d.rdata = load_val;
        end
        wr_en_d = wr_i && !misal_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH_WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en_d) begin
            mem_q[idx_c] <= merged;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign misalign_o = st_q.misalign;

    AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || wr_i) && size_i && (addr_i[1:0] != 2'b00)) |=> misalign_o); // R6

    AST_MISALIGN_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && size_i && (addr_i[1:0] != 2'b00)) |=> $stable(rdata_o)); // R6

    AST_BYTE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!size_i || !(rd_i || wr_i)) |=> !misalign_o); // R7

    AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i) |=> $stable(rdata_o)); // R9

    AST_BYTE_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !size_i) |=> (rdata_o[31:8] == {24{rdata_o[7]}})); // R4

endmodule

// File: tb/byte_word_dmem_tb_top.sv
`timescale 1ns/1ps
module byte_word_dmem_tb_top;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        size_i = 1'b0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [31:0] rdata_o;
    logic        misalign_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] ref_mem [DEPTH];
    logic [31:0] ref_rd;
    logic        ref_err;

    always #2.5 clk = ~clk;

    byte_word_dmem #(.DEPTH_WORDS(DEPTH), .ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .size_i(size_i), .rd_i(rd_i), .wr_i(wr_i),
        .rdata_o(rdata_o), .misalign_o(misalign_o)
    );

    task automatic check(input string tag);
        checks++;
        if (rdata_o !== ref_rd) begin
            failures++;
            $display("FAIL %s rdata actual=%08h expected=%08h", tag, rdata_o, ref_rd);
        end
        checks++;
        if (misalign_o !== ref_err) begin
            failures++;
            $display("FAIL %s misalign actual=%0b expected=%0b", tag, misalign_o, ref_err);
        end
    endtask

    // One bus cycle: drive, update the behavioural model, sample after the edge.
    task automatic cyc(input bit rd, input bit wr, input bit word,
                       input logic [31:0] a, input logic [31:0] wd, input string tag);
        int idx;
        int off;
        bit bad;
        logic [7:0] b;
        addr_i = a; wdata_i = wd; size_i = word; rd_i = rd; wr_i = wr;
        idx = int'((a >> 2) % DEPTH);
        off = int'(a % 4);
        bad = word && (off != 0) && (rd || wr);
        ref_err = bad;
        if (rd && !bad) begin
            if (word) ref_rd = ref_mem[idx];
            else begin
                b = ref_mem[idx][(3-off)*8 +: 8];
                ref_rd = 32'(signed'(b));
            end
        end
        if (wr && !bad) begin
            if (word) ref_mem[idx] = wd;
            else ref_mem[idx][(3-off)*8 +: 8] = wd[7:0];
        end
        @(posedge clk);
        @(negedge clk);
        rd_i = 0; wr_i = 0;
        check(tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        ref_rd = '0; ref_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1");
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, 32'(i * 4), 0, "R1");

        // R2: full words
        cyc(0, 1, 1, 32'h10, 32'hDEADBEEF, "R2");
        cyc(0, 1, 1, 32'hFC, 32'h01234567, "R2");
        cyc(1, 0, 1, 32'h10, 0, "R2");
        cyc(1, 0, 1, 32'hFC, 0, "R2");

        // R3, R4: lane order and sign extension
        cyc(0, 1, 1, 32'h20, 32'h8123A4C5, "R3");
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 32'(32'h20 + k), 0, "R3");
        cyc(1, 0, 0, 32'h20, 0, "R4");
        cyc(1, 0, 0, 32'h21, 0, "R4");

        // R5: byte store per lane
        cyc(0, 1, 1, 32'h30, 32'h11223344, "R5");
        for (int k = 0; k < 4; k++) begin
            cyc(0, 1, 0, 32'(32'h30 + k), 32'(32'hA0 + k), "R5");
            cyc(1, 0, 1, 32'h30, 0, "R5");
        end

        // R6: misaligned word accesses
        cyc(0, 1, 1, 32'h11, 32'h55555555, "R6");
        cyc(1, 0, 1, 32'h10, 0, "R6");
        cyc(1, 0, 1, 32'h13, 0, "R6");
        cyc(0, 1, 1, 32'h12, 32'h66666666, "R6");
        cyc(1, 0, 1, 32'h10, 0, "R6");

        // R7: byte access at odd address, idle
        cyc(1, 0, 0, 32'h13, 0, "R7");
        cyc(0, 1, 0, 32'h11, 32'h7F, "R7");
        cyc(0, 0, 1, 32'h13, 0, "R7");

        // R8: aliasing above the index
        cyc(0, 1, 1, 32'(DEPTH * 4 + 8), 32'hCAFEF00D, "R8");
        cyc(1, 0, 1, 32'h8, 0, "R8");
        cyc(1, 0, 1, 32'hFFFF_0008 | 32'(DEPTH * 4), 0, "R8");

        // R9: hold while not reading
        cyc(0, 0, 1, 32'h20, 0, "R9");
        cyc(0, 1, 1, 32'h8, 32'h0BADCAFE, "R9");

        // R10: read and write same word in one cycle
        cyc(1, 1, 1, 32'h40, 32'h12345678, "R10");
        cyc(1, 1, 0, 32'h42, 32'h000000EE, "R10");
        cyc(1, 0, 1, 32'h40, 0, "R10");

        // Mixed stream compared every clock (R2 main path)
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0], r[1], r[2], {24'h0, r[15:8]} | (r[3] ? 32'(DEPTH * 4) : 0),
                $urandom, "R2");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule